// File: doc/BRIEF.md
# Timer Control and Status Interrupt Unit

This block holds the control word and the status word shared by three CPU timers: a count-down decrementer, a fixed-interval timer and a watchdog. Software writes the control word to choose periods, the watchdog reset action, auto-reload and the three interrupt enables. The block passes the decoded control fields to the timer blocks. Each timer sends a single-cycle event pulse when it expires, and that pulse latches a status bit.

Software clears a status bit by writing a one to its position in the status word. Each interrupt output is a level. It is high whenever a status bit and its enable are both set, so an enable written while the status is already pending raises the interrupt without waiting for another event. The parameter `EXT_EN` chooses whether the two 4-bit period extension fields are passed to the timers or forced to zero.

Top module: `tmr_ctl_stat`

## Requirements
- R1: After reset the control word, the status word and all three interrupt outputs are zero.
- R2: A control write (`ctl_we_i`) stores all 32 bits of `wdata_i`, reserved bits included. `ctl_o` returns the stored word and changes only on a control write.
- R3: Control field decode:
  - `wdt_per_o` = {ctl[20:17], ctl[31:30]} and `fit_per_o` = {ctl[16:13], ctl[25:24]}. With `EXT_EN`=0 the upper four bits of each are zero.
  - `wdt_rc_o` = ctl[29:28].
  - `arld_o` = ctl[22].
- R4: A pulse on `wdt_evt_i`, `dec_evt_i` or `fit_evt_i` sets status bit 30, 27 or 26 respectively on the next edge, whatever the enable bits hold.
- R5: A status write (`sts_we_i`) clears each status bit where `wdata_i` holds a one and leaves bits written as zero unchanged. Status bits 25:0 always read zero.
- R6: The interrupts are levels:
  - `wdt_irq_o` = status[30] & ctl[27].
  - `dec_irq_o` = status[27] & ctl[26].
  - `fit_irq_o` = status[26] & ctl[23].
- R7: Setting an enable bit while its status bit is pending raises that interrupt right after the control write, with no new event.
- R8: When an event and a status clear hit the same bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control word write strobe |
| sts_we_i | input | 1 | Status word write-one-to-clear strobe |
| wdata_i | input | 32 | Write data for both strobes |
| ctl_o | output | 32 | Control word read value |
| sts_o | output | 32 | Status word read value |
| dec_evt_i | input | 1 | Decrementer expiry pulse |
| fit_evt_i | input | 1 | Fixed-interval expiry pulse |
| wdt_evt_i | input | 1 | Watchdog expiry pulse |
| dec_irq_o | output | 1 | Decrementer interrupt level |
| fit_irq_o | output | 1 | Fixed-interval interrupt level |
| wdt_irq_o | output | 1 | Watchdog interrupt level |
| wdt_per_o | output | 6 | Watchdog period select |
| fit_per_o | output | 6 | Fixed-interval period select |
| wdt_rc_o | output | 2 | Watchdog reset control |
| arld_o | output | 1 | Decrementer auto-reload enable |

## Verification
The hardest case to reach is a status clear that lands in the same cycle as an event on the same bit. The other hard case is an enable written while its status is already latched with the interrupt masked. Directed sequences set up both: an event is first latched with the enable off, then either the enable is written or a clear and a new event are issued together. Random traffic then applies events and writes at high density, so that these collisions and late-enable cases also occur many times at random.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WORD_W = 32;
  localparam int BASE_W = 2;
  localparam int EXT_W  = 4;
  localparam int PER_W  = BASE_W + EXT_W;

  // control word positions
  localparam int C_WDT_PER = 30;
  localparam int C_WDT_RC  = 28;
  localparam int C_WDT_IE  = 27;
  localparam int C_DEC_IE  = 26;
  localparam int C_FIT_PER = 24;
  localparam int C_FIT_IE  = 23;
  localparam int C_ARLD    = 22;
  localparam int C_WDT_EXT = 17;
  localparam int C_FIT_EXT = 13;

  // status word positions
  localparam int S_WDT_ST = 30;
  localparam int S_DEC_ST = 27;
  localparam int S_FIT_ST = 26;
  localparam logic [WORD_W-1:0] S_DEF_MASK = 32'hFC00_0000;

  typedef struct packed {
    logic [PER_W-1:0] wdt_per;
    logic [1:0]       wdt_rc;
    logic             wdt_ie;
    logic             dec_ie;
    logic [PER_W-1:0] fit_per;
    logic             fit_ie;
    logic             arld;
  } tcr_fields_t;
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
  import tmr_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] q_o,
  output tcr_fields_t       fld_o
);
  logic [WORD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i;
  end

  logic [EXT_W-1:0] wdt_ext, fit_ext;

  generate
    if (EXT_EN) begin : g_ext
      assign wdt_ext = q[C_WDT_EXT +: EXT_W];
      assign fit_ext = q[C_FIT_EXT +: EXT_W];
    end else begin : g_no_ext
      assign wdt_ext = '0;
      assign fit_ext = '0;
    end
  endgenerate

  always_comb begin
    fld_o.wdt_per = {wdt_ext, q[C_WDT_PER +: BASE_W]};
    fld_o.fit_per = {fit_ext, q[C_FIT_PER +: BASE_W]};
    fld_o.wdt_rc  = q[C_WDT_RC +: 2];
    fld_o.wdt_ie  = q[C_WDT_IE];
    fld_o.dec_ie  = q[C_DEC_IE];
    fld_o.fit_ie  = q[C_FIT_IE];
    fld_o.arld    = q[C_ARLD];
  end

  assign q_o = q;
endmodule

// File: rtl/tmr_sts_reg.sv
module tmr_sts_reg
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              wdt_set_i,
  input  logic              dec_set_i,
  input  logic              fit_set_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] q, clr, set;

  always_comb begin
    clr = we_i ? (wdata_i & S_DEF_MASK) : '0;
    set = '0;
    set[S_WDT_ST] = wdt_set_i;
    set[S_DEC_ST] = dec_set_i;
    set[S_FIT_ST] = fit_set_i;
  end

  // set after clear: a same-cycle event survives the clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr) | set;
  end

  assign q_o = q;
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] irq_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_lane
      assign irq_o[i] = sts_i[i] & en_i[i];
    end
  endgenerate
endmodule

// File: rtl/tmr_ctl_stat.sv
module tmr_ctl_stat
  import tmr_pkg::*;
#(
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              sts_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctl_o,
  output logic [WORD_W-1:0] sts_o,
  input  logic              dec_evt_i,
  input  logic              fit_evt_i,
  input  logic              wdt_evt_i,
  output logic              dec_irq_o,
  output logic              fit_irq_o,
  output logic              wdt_irq_o,
  output logic [PER_W-1:0]  wdt_per_o,
  output logic [PER_W-1:0]  fit_per_o,
  output logic [1:0]        wdt_rc_o,
  output logic              arld_o
);
  localparam int N_IRQ = 3;

  tcr_fields_t       fld;
  logic [N_IRQ-1:0]  irq;

  tmr_ctl_reg #(.EXT_EN(EXT_EN)) i_ctl (
    .clk_i, .rst_ni, .we_i(ctl_we_i), .wdata_i, .q_o(ctl_o), .fld_o(fld)
  );

  tmr_sts_reg i_sts (
    .clk_i, .rst_ni, .we_i(sts_we_i), .wdata_i,
    .wdt_set_i(wdt_evt_i), .dec_set_i(dec_evt_i), .fit_set_i(fit_evt_i),
    .q_o(sts_o)
  );

  tmr_irq_gate #(.N(N_IRQ)) i_gate (
    .sts_i({sts_o[S_WDT_ST], sts_o[S_DEC_ST], sts_o[S_FIT_ST]}),
    .en_i ({fld.wdt_ie, fld.dec_ie, fld.fit_ie}),
    .irq_o(irq)
  );

  assign {wdt_irq_o, dec_irq_o, fit_irq_o} = irq;
  assign wdt_per_o = fld.wdt_per;
  assign fit_per_o = fld.fit_per;
  assign wdt_rc_o  = fld.wdt_rc;
  assign arld_o    = fld.arld;
endmodule

// File: rtl/tmr_ctl_stat_chk.sv
module tmr_ctl_stat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctl_we_i,
  input logic        sts_we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] ctl_o,
  input logic [31:0] sts_o,
  input logic        dec_evt_i,
  input logic        wdt_evt_i,
  input logic        dec_irq_o,
  input logic        wdt_irq_o
);
  AST_CTL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i |=> ctl_o == $past(wdata_i)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_we_i |=> $stable(ctl_o)); // R2
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_evt_i |=> sts_o[27]); // R4
  AST_EVT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_evt_i && sts_we_i && wdata_i[30]) |=> sts_o[30]); // R8
  AST_CLR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && wdata_i[27] && !dec_evt_i) |=> !sts_o[27]); // R5
  AST_NO_STRAY_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_we_i |=> !$fell(sts_o[27])); // R5
  AST_DEC_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_irq_o |-> (sts_o[27] && ctl_o[26])); // R6
  AST_WDT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_o[30] && ctl_o[27]) |-> wdt_irq_o); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_o[25:0] == '0); // R5
endmodule

bind tmr_ctl_stat tmr_ctl_stat_chk i_chk (
  .clk_i, .rst_ni, .ctl_we_i, .sts_we_i, .wdata_i, .ctl_o, .sts_o,
  .dec_evt_i, .wdt_evt_i, .dec_irq_o, .wdt_irq_o
);

// File: tb/test_tmr_ctl_stat.sv
module test_tmr_ctl_stat;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_we_i = 1'b0, sts_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] ctl_o, sts_o;
  logic        dec_evt_i = 1'b0, fit_evt_i = 1'b0, wdt_evt_i = 1'b0;
  logic        dec_irq_o, fit_irq_o, wdt_irq_o;
  logic [5:0]  wdt_per_o, fit_per_o;
  logic [1:0]  wdt_rc_o;
  logic        arld_o;

  int n_vec = 0, n_err = 0;
  logic [31:0] m_ctl = '0, m_sts = '0;

  always #2 clk_i = ~clk_i;

  tmr_ctl_stat i_tmr_ctl_stat (.*);

  function automatic logic [2:0] irq_exp(logic [31:0] c, logic [31:0] s);
    return {s[30] & c[27], s[27] & c[26], s[26] & c[23]};
  endfunction

  function automatic logic [31:0] sts_next(logic [31:0] s, logic we, logic [31:0] d,
                                           logic w, logic de, logic f);
    logic [31:0] n;
    n = s & ~(we ? (d & 32'hFC00_0000) : 32'h0);
    if (w)  n[30] = 1'b1;
    if (de) n[27] = 1'b1;
    if (f)  n[26] = 1'b1;
    return n;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2", ctl_o, m_ctl);
    chk("R5", sts_o, m_sts);
    chk("R6", {29'd0, wdt_irq_o, dec_irq_o, fit_irq_o}, {29'd0, irq_exp(m_ctl, m_sts)});
    chk("R3", {20'd0, wdt_per_o, fit_per_o},
        {20'd0, m_ctl[20:17], m_ctl[31:30], m_ctl[16:13], m_ctl[25:24]});
    chk("R3", {29'd0, wdt_rc_o, arld_o}, {29'd0, m_ctl[29:28], m_ctl[22]});
  endtask

  // drive at negedge, model updates on edge, compare at next negedge
  task automatic step(logic cw, logic sw, logic [31:0] d, logic w, logic de, logic f);
    ctl_we_i = cw; sts_we_i = sw; wdata_i = d;
    wdt_evt_i = w; dec_evt_i = de; fit_evt_i = f;
    @(posedge clk_i);
    m_sts = sts_next(m_sts, sw, d, w, de, f);
    if (cw) m_ctl = d;
    @(negedge clk_i);
    ctl_we_i = 0; sts_we_i = 0; wdt_evt_i = 0; dec_evt_i = 0; fit_evt_i = 0;
    check_all();
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", sts_o, 32'h0);
    chk("R1", ctl_o, 32'h0);
    chk("R1", {29'd0, wdt_irq_o, dec_irq_o, fit_irq_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 reserved control bits kept
    step(1, 0, 32'h0020_1FFF, 0, 0, 0);
    // R3 full period decode
    step(1, 0, 32'hF3C1_E000, 0, 0, 0);
    step(1, 0, 32'h0, 0, 0, 0);
    // R4 events latch with all enables off, no irq
    step(0, 0, 32'h0, 1, 1, 1);
    chk("R4", sts_o, 32'h4C00_0000);
    // R7 enable with pending status raises at once
    step(1, 0, 32'h0C80_0000, 0, 0, 0);
    chk("R7", {29'd0, wdt_irq_o, dec_irq_o, fit_irq_o}, 32'h7);
    // R5 clear dec only, zeros leave others
    step(0, 1, 32'h0800_0000, 0, 0, 0);
    chk("R5", {29'd0, wdt_irq_o, dec_irq_o, fit_irq_o}, 32'h5);
    // R8 clear and event on same bit
    step(0, 1, 32'h4400_0000, 1, 0, 0);
    chk("R8", sts_o, 32'h4000_0000);
    // R6 clearing the enable drops the level
    step(1, 0, 32'h0, 0, 0, 0);
    chk("R6", {31'd0, wdt_irq_o}, 32'h0);
    step(0, 1, 32'hFFFF_FFFF, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      d = $urandom();
      step(($urandom % 4) == 0, ($urandom % 3) == 0, d,
           ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule